// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address. It walks a two-level page table that sits in ordinary memory. Software loads two registers at a context switch. The table base register gives the byte address of the outer table. The table length register gives how many outer entries are legal. A new process is selected by reloading the base register alone.

A request carries a virtual address. The walker cuts the address into three fields: an outer index, an inner index and a byte offset within a 1 KB page. It rejects an outer index that reaches or passes the length register. Otherwise it reads the outer entry and then the inner entry through a simple memory port. Each memory read is a held request that is answered by a one-cycle valid pulse. The response is either the physical address or a fault code that names the stage that stopped the walk.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `resp_valid` and `mem_req` are 0. The base and length registers hold 0, so a first walk ends in the bound fault.
- R2: The virtual address is split as follows: bits [31:20] form the outer index, bits [19:10] form the inner index and bits [9:0] form the offset.
- R3: A request whose outer index is greater than or equal to the length register ends with `resp_code` = 1 and `resp_paddr` = 0. `resp_valid` rises in the cycle after acceptance, and no memory read is issued.
- R4: The first read of a walk is at `base + 4*outer_index`, taken modulo 2^32.
- R5: If bit 0 of the outer entry is 0, the walk ends with `resp_code` = 2 and no second read is issued.
- R6: The second read is at `{outer_entry[31:10], 10'b0} + 4*inner_index`.
- R7: If bit 0 of the inner entry is 0, the walk ends with `resp_code` = 3.
- R8: On success `resp_code` is 0 and `resp_paddr` = `{inner_entry[31:10], offset}`. On any fault `resp_paddr` is 0.
- R9: `mem_req` stays high with a steady `mem_addr` until `mem_valid` answers it. `mem_valid` is taken only while `mem_req` is high.
- R10: `req_ready` is high only while no walk is in progress. A `req_valid` seen while busy is ignored. `resp_valid` lasts exactly one cycle.
- R11: A write to the base or length register takes effect for the next accepted walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Load enable for the table base register |
| base_wdata | input | 32 | New table base byte address |
| limit_we | input | 1 | Load enable for the table length register |
| limit_wdata | input | 13 | New number of legal outer entries (0 to 4096) |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle; a request is taken on this edge |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_code | output | 2 | 0 ok, 1 bound, 2 outer invalid, 3 inner invalid |
| resp_paddr | output | 32 | Physical address, 0 on a fault |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | 32 | Memory read byte address |
| mem_valid | input | 1 | Read data valid, one cycle |
| mem_rdata | input | 32 | Table entry read from memory |

## Verification
Random addresses are run against a pseudo-memory whose entries are a hash of their address, so roughly one entry in eight is invalid. This exercises all four end states, and it separates a correct address computation from a wrong one, because a wrong read address returns a different hash. Outer indices just below and at the length limit, and a zero limit, pin the bound comparison down against an off-by-one error. A change of the base register between walks shows that the new table is used. Requests pushed during a busy walk show that they are ignored. Random memory latency checks that the read address is held and that the data is taken only on the valid pulse.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_RD_OUTER = 2'd1,
    ST_RD_INNER = 2'd2,
    ST_DONE     = 2'd3
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_BOUND = 2'd1,
    FLT_OUTER = 2'd2,
    FLT_INNER = 2'd3
  } flt_code_e;
endpackage

// File: rtl/ptw_regs.sv
module ptw_regs #(
  parameter int AW = 32,
  parameter int LW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic          limit_we,
  input  logic [LW-1:0] limit_wdata,
  output logic [AW-1:0] base_q,
  output logic [LW-1:0] limit_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= base_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        limit_q <= '0;
    else if (limit_we) limit_q <= limit_wdata;
  end
endmodule

// File: rtl/ptw_addr.sv
module ptw_addr #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10,
  parameter int P2_W  = 10,
  localparam int P1_W  = VA_W - OFF_W - P2_W,
  localparam int LIM_W = P1_W + 1,
  localparam int FRM_W = VA_W - OFF_W
) (
  input  logic [P1_W-1:0]  req_p1,
  input  logic [LIM_W-1:0] limit_q,
  input  logic [VA_W-1:0]  base_q,
  input  logic [P1_W-1:0]  cur_p1,
  input  logic [P2_W-1:0]  cur_p2,
  input  logic [FRM_W-1:0] frame_q,
  output logic             out_of_range,
  output logic [VA_W-1:0]  outer_addr,
  output logic [VA_W-1:0]  inner_addr
);
  // Entries are 4 bytes wide, so each index is scaled by 4.
  logic [VA_W-1:0] p1_bytes, p2_bytes;

  always_comb begin
    out_of_range = ({1'b0, req_p1} >= limit_q);
    p1_bytes     = {{(VA_W-P1_W-2){1'b0}}, cur_p1, 2'b00};
    p2_bytes     = {{(VA_W-P2_W-2){1'b0}}, cur_p2, 2'b00};
    outer_addr   = base_q + p1_bytes;
    inner_addr   = {frame_q, {OFF_W{1'b0}}} + p2_bytes;
  end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10,
  localparam int FRM_W = VA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             out_of_range,
  input  logic             mem_valid,
  input  logic [VA_W-1:0]  mem_rdata,
  output logic             req_ready,
  output logic             mem_req,
  output logic             sel_inner,
  output logic             resp_valid,
  output logic [1:0]       resp_code,
  output logic [VA_W-1:0]  resp_paddr,
  output logic [VA_W-1:0]  va_q,
  output logic [FRM_W-1:0] frame_q
);
  walk_state_e state_q, state_d;
  logic        accept, outer_ok, va_en, frame_en, res_en;
  flt_code_e   code_d;
  logic [1:0]  code_q;
  logic [VA_W-1:0] paddr_d, paddr_q;
  logic [OFF_W-2:0] unused_rdata;

  assign unused_rdata = mem_rdata[OFF_W-1:1];
  assign accept       = (state_q == ST_IDLE) && req_valid;
  assign outer_ok     = mem_rdata[0];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_valid) state_d = out_of_range ? ST_DONE : ST_RD_OUTER;
      ST_RD_OUTER: if (mem_valid) state_d = outer_ok ? ST_RD_INNER : ST_DONE;
      ST_RD_INNER: if (mem_valid) state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    code_d  = FLT_BOUND;
    paddr_d = '0;
    unique case (state_q)
      ST_RD_OUTER: code_d = FLT_OUTER;
      ST_RD_INNER: begin
        if (mem_rdata[0]) begin
          code_d  = FLT_NONE;
          paddr_d = {mem_rdata[VA_W-1:OFF_W], va_q[OFF_W-1:0]};
        end else begin
          code_d  = FLT_INNER;
        end
      end
      default: code_d = FLT_BOUND;
    endcase
  end

  assign va_en    = accept;
  assign frame_en = (state_q == ST_RD_OUTER) && mem_valid && outer_ok;
  assign res_en   = (accept && out_of_range)
                 || ((state_q == ST_RD_OUTER) && mem_valid && !outer_ok)
                 || ((state_q == ST_RD_INNER) && mem_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     va_q <= '0;
    else if (va_en) va_q <= req_vaddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frame_q <= '0;
    else if (frame_en) frame_q <= mem_rdata[VA_W-1:OFF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      paddr_q <= '0;
    end else if (res_en) begin
      code_q  <= code_d;
      paddr_q <= paddr_d;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign mem_req    = (state_q == ST_RD_OUTER) || (state_q == ST_RD_INNER);
  assign sel_inner  = (state_q == ST_RD_INNER);
  assign resp_valid = (state_q == ST_DONE);
  assign resp_code  = code_q;
  assign resp_paddr = paddr_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10,
  parameter int P2_W  = 10,
  localparam int P1_W  = VA_W - OFF_W - P2_W,
  localparam int LIM_W = P1_W + 1,
  localparam int FRM_W = VA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [VA_W-1:0]  base_wdata,
  input  logic             limit_we,
  input  logic [LIM_W-1:0] limit_wdata,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  output logic             resp_valid,
  output logic [1:0]       resp_code,
  output logic [VA_W-1:0]  resp_paddr,
  output logic             mem_req,
  output logic [VA_W-1:0]  mem_addr,
  input  logic             mem_valid,
  input  logic [VA_W-1:0]  mem_rdata
);
  // Reset is asserted asynchronously and released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [VA_W-1:0]  base_q;
  logic [LIM_W-1:0] limit_q;
  logic [VA_W-1:0]  va_q, outer_addr, inner_addr;
  logic [FRM_W-1:0] frame_q;
  logic             out_of_range, sel_inner;

  ptw_regs #(.AW(VA_W), .LW(LIM_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .base_we(base_we), .base_wdata(base_wdata),
    .limit_we(limit_we), .limit_wdata(limit_wdata),
    .base_q(base_q), .limit_q(limit_q)
  );

  ptw_addr #(.VA_W(VA_W), .OFF_W(OFF_W), .P2_W(P2_W)) u_addr (
    .req_p1(req_vaddr[VA_W-1 -: P1_W]),
    .limit_q(limit_q),
    .base_q(base_q),
    .cur_p1(va_q[VA_W-1 -: P1_W]),
    .cur_p2(va_q[OFF_W +: P2_W]),
    .frame_q(frame_q),
    .out_of_range(out_of_range),
    .outer_addr(outer_addr),
    .inner_addr(inner_addr)
  );

  ptw_fsm #(.VA_W(VA_W), .OFF_W(OFF_W)) u_fsm (
    .clk(clk), .rst_n(rst_int_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr),
    .out_of_range(out_of_range),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .req_ready(req_ready), .mem_req(mem_req), .sel_inner(sel_inner),
    .resp_valid(resp_valid), .resp_code(resp_code), .resp_paddr(resp_paddr),
    .va_q(va_q), .frame_q(frame_q)
  );

  assign mem_addr = sel_inner ? inner_addr : outer_addr;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int VA_W  = 32,
  parameter int P1_W  = 12,
  parameter int LIM_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic [LIM_W-1:0] limit_q,
  input logic             mem_req,
  input logic [VA_W-1:0]  mem_addr,
  input logic             mem_valid,
  input logic [VA_W-1:0]  mem_rdata,
  input logic             resp_valid,
  input logic [1:0]       resp_code
);
  assert_bound_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ({1'b0, req_vaddr[VA_W-1 -: P1_W]} >= limit_q))
      |=> (resp_valid && resp_code == 2'd1 && !mem_req));

  assert_stop_on_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid && !mem_rdata[0]) |=> !mem_req);

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !resp_valid));

  assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
endmodule

bind pt_walker ptw_checker #(.VA_W(VA_W), .P1_W(P1_W), .LIM_W(LIM_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
  .limit_q(limit_q),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
  .mem_rdata(mem_rdata),
  .resp_valid(resp_valid), .resp_code(resp_code)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic        clk, rst_n;
  logic        base_we, limit_we, req_valid, mem_valid;
  logic [31:0] base_wdata, req_vaddr, mem_rdata;
  logic [12:0] limit_wdata;
  logic        req_ready, resp_valid, mem_req;
  logic [1:0]  resp_code;
  logic [31:0] resp_paddr, mem_addr;

  int n_checks = 0, n_fail = 0;
  logic [31:0] salt = 32'h1234_5678;
  logic [31:0] cur_base = 0;
  logic [12:0] cur_limit = 0;
  logic [31:0] rd_addr [4];
  int          rd_n = 0;
  int          wait_cnt = 0;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n),
    .base_we(base_we), .base_wdata(base_wdata),
    .limit_we(limit_we), .limit_wdata(limit_wdata),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_code(resp_code), .resp_paddr(resp_paddr),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // Table entries are a hash of their address; about 1 in 8 is invalid.
  function automatic logic [31:0] mem_f(input logic [31:0] a);
    logic [31:0] x;
    x = (a ^ salt) * 32'h9E37_79B1;
    x = x ^ (x >> 15);
    x = x * 32'h85EB_CA6B;
    x = x ^ (x >> 13);
    return {x[31:1], (x[4:2] != 3'b000)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model: answers a held request after 0..2 idle cycles.
  initial begin
    mem_valid = 0;
    mem_rdata = 0;
    forever begin
      @(negedge clk);
      if (mem_valid) begin
        mem_valid = 0;
      end else if (mem_req) begin
        if (wait_cnt == 0) begin
          if (rd_n < 4) rd_addr[rd_n] = mem_addr;
          rd_n++;
          mem_rdata = mem_f(mem_addr);
          mem_valid = 1;
          wait_cnt = $urandom % 3;
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  task automatic load_regs(input logic [31:0] b, input logic [12:0] l);
    @(negedge clk);
    base_we = 1; base_wdata = b; limit_we = 1; limit_wdata = l;
    @(negedge clk);
    base_we = 0; limit_we = 0;
    cur_base = b; cur_limit = l;
  endtask

  task automatic walk(input logic [31:0] va, input bit poke_busy);
    logic [11:0] p1; logic [9:0] p2, off;
    logic [31:0] e1, e2, oa, ia, exp_pa;
    logic [1:0]  exp_code;
    int exp_reads, lat;
    p1 = va[31:20]; p2 = va[19:10]; off = va[9:0];
    oa = cur_base + {18'd0, p1, 2'b00};
    e1 = mem_f(oa);
    ia = {e1[31:10], 10'd0} + {20'd0, p2, 2'b00};
    e2 = mem_f(ia);
    exp_pa = 0;
    if ({1'b0, p1} >= cur_limit) begin exp_code = 1; exp_reads = 0; end
    else if (!e1[0])             begin exp_code = 2; exp_reads = 1; end
    else if (!e2[0])             begin exp_code = 3; exp_reads = 2; end
    else begin exp_code = 0; exp_reads = 2; exp_pa = {e2[31:10], off}; end

    @(negedge clk);
    rd_n = 0;
    req_valid = 1; req_vaddr = va;
    @(negedge clk);
    if (poke_busy) req_vaddr = ~va; else req_valid = 0;
    lat = 0;
    while (!resp_valid && lat < 100) begin
      if (poke_busy) chk(req_ready == 0, "R10 ready low while busy", {31'd0, req_ready}, 0);
      @(negedge clk);
      lat++;
    end
    req_valid = 0;
    chk(lat < 100, "R10 walk timeout", lat, 0);
    chk(resp_code == exp_code, "R3/R5/R7 fault code", {30'd0, resp_code}, {30'd0, exp_code});
    chk(resp_paddr == exp_pa, "R8 paddr", resp_paddr, exp_pa);
    chk(rd_n == exp_reads, "R3/R5 read count", rd_n, exp_reads);
    if (exp_code == 1) chk(lat == 0, "R3 bound latency", lat, 0);
    if (exp_reads >= 1) chk(rd_addr[0] == oa, "R4 outer addr (R2 split)", rd_addr[0], oa);
    if (exp_reads == 2) chk(rd_addr[1] == ia, "R6 inner addr (R2 split)", rd_addr[1], ia);
    @(negedge clk);
    chk(resp_valid == 0 && req_ready == 1, "R10 single-cycle resp", {31'd0, resp_valid}, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    base_we = 0; limit_we = 0; base_wdata = 0; limit_wdata = 0;
    req_valid = 0; req_vaddr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1 && resp_valid == 0 && mem_req == 0, "R1 reset outputs",
        {29'd0, req_ready, resp_valid, mem_req}, 32'h4);
    walk(32'h0000_0123, 0);          // R1: zero length faults
    walk(32'hFFFF_FFFF, 0);

    load_regs(32'h0010_0000, 13'd16);
    walk({12'd15, 10'd3, 10'h2A}, 0); // R3 below limit
    walk({12'd16, 10'd3, 10'h2A}, 0); // R3 at limit
    load_regs(32'hFFFF_FFF0, 13'd4096);
    walk({12'd4095, 10'd1023, 10'h3FF}, 0); // R4 wrap, full length
    walk({12'd0, 10'd0, 10'd0}, 0);

    // R11: same vaddr under a new base reads a new table
    load_regs(32'h0800_0000, 13'd64);
    walk(32'h0030_5555, 0);
    load_regs(32'h0900_0400, 13'd64);
    walk(32'h0030_5555, 0);

    // R10: requests held during a walk are ignored
    for (int i = 0; i < 20; i++) walk({12'(i), 20'($urandom)}, 1);

    for (int i = 0; i < 1500; i++) begin
      if (i % 100 == 0) begin
        salt = $urandom;
        load_regs({$urandom} & 32'hFFFF_FFFC, 13'(2048 + ($urandom % 2049)));
      end
      walk($urandom, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule